// File: doc/BRIEF.md
# Prescaled Compare-Match Interval Timer

This block generates periodic interrupt requests for one or more independent channels. A single free-running prescaler, shared by every channel, makes one-cycle enable pulses at the peripheral clock divided by 8, 32, 128 and 512. Each channel selects one of these pulses. While its run bit is set, the channel advances a 16-bit up-counter on that pulse. When the counter equals the channel's compare value on a pulse, the counter returns to zero and a sticky match flag is set. The channel's interrupt request is the flag gated by its enable bit.

Software uses a simple register port with a write strobe, a read strobe, an address and 16-bit write and read data. Each channel has three registers: control, count and compare. The read data is combinational from the address. The match flag is cleared with a read-then-write handshake, so that an event which software has not yet seen is never lost.

Top module: `cmt_top`

## Requirements
- R1: After reset, every control register reads 0x0000, every count reads 0x0000, every compare reads 0xFFFF and all interrupt requests are low.
- R2: Control bits [2:1] select the count pulse. The codes 0, 1, 2 and 3 give the clock divided by 8, 32, 128 and 512. The counter advances by one per selected pulse.
- R3: On a selected pulse where count equals compare, the counter goes to 0x0000 and the match flag (control bit 4) is set. The time from one match to the next is therefore (compare+1) × divisor clock cycles. A match wins over a flag clear in the same cycle.
- R4: A channel's interrupt request is high exactly when its match flag and its enable bit (control bit 3) are both 1.
- R5: A control write with bit 4 at 0 clears the flag only if software has read control with the flag at 1 since the last control write. Writing bit 4 as 1 never sets the flag.
- R6: With the run bit (control bit 0) at 0, the counter holds its value. Setting the run bit again resumes counting from the held value.
- R7: Writes to count and compare take effect on the next edge and read back. A count write takes priority over an increment in the same cycle.
- R8: The address is channel×4 + offset, with offset 0 for control, 1 for count and 2 for compare. Offset 3 reads 0x0000. Channels are independent: each has its own request output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr | input | ADDR_W (3) | Channel and register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | NCH (2) | Interrupt request per channel |

## Verification
The assertions assume that the read and write strobes are never asserted in the same cycle. They also assume that a read strobe stays high for one cycle per access. The bench drives every access through one-cycle tasks that keep to these rules. The bench clears a flag only after it has observed the request, so every clear falls well inside a period. A same-cycle clash between a clear and a match is therefore left to the flag assertions. The period measurements use only request edges, so the fixed prescaler phase has no effect on the expected values.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam logic [1:0] OFF_CTRL  = 2'd0;
    localparam logic [1:0] OFF_COUNT = 2'd1;
    localparam logic [1:0] OFF_CMP   = 2'd2;

    localparam int BIT_RUN  = 0;
    localparam int BIT_SEL  = 1;
    localparam int BIT_IE   = 3;
    localparam int BIT_FLAG = 4;
endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale #(
    parameter int NSEL   = 4,
    parameter int BASE_W = 3,
    parameter int STEP_W = 2,
    localparam int PRE_W = BASE_W + STEP_W * (NSEL - 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [NSEL-1:0] tick_o
);
    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb pre_d = pre_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    for (genvar k = 0; k < NSEL; k++) begin : g_tick
        localparam int HB = BASE_W + STEP_W * k - 1;
        assign tick_o[k] = &pre_q[HB:0];
    end

    // R2
    slow_implies_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o[NSEL-1] |-> tick_o[0]);

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o[0] |=> !tick_o[0]);
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 2,
    parameter int NSEL  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSEL-1:0]  tick_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [1:0]       off_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    output logic             irq_o
);
    typedef struct packed {
        logic             run;
        logic [SEL_W-1:0] sel;
        logic             ie;
        logic             flag;
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cmp;
    } chan_t;

    chan_t s_d, s_q;
    logic  sel_tick, match, ctrl_wr, cnt_wr, cmp_wr, ctrl_rd;

    assign ctrl_wr  = wr_i && (off_i == OFF_CTRL);
    assign cnt_wr   = wr_i && (off_i == OFF_COUNT);
    assign cmp_wr   = wr_i && (off_i == OFF_CMP);
    assign ctrl_rd  = rd_i && (off_i == OFF_CTRL);
    assign sel_tick = tick_i[s_q.sel];

    always_comb begin
        s_d   = s_q;
        match = 1'b0;
        if (s_q.run && sel_tick) begin
            if (s_q.cnt == s_q.cmp) begin
                s_d.cnt = '0;
                match   = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        if (ctrl_rd && s_q.flag) s_d.armed = 1'b1;
        if (ctrl_wr) begin
            s_d.run = wdata_i[BIT_RUN];
            s_d.sel = wdata_i[BIT_SEL +: SEL_W];
            s_d.ie  = wdata_i[BIT_IE];
            if (!wdata_i[BIT_FLAG] && s_q.armed) s_d.flag = 1'b0;
            s_d.armed = 1'b0;
        end
        if (cnt_wr) s_d.cnt = wdata_i;
        if (cmp_wr) s_d.cmp = wdata_i;
        if (match)  s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cmp <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (off_i)
            OFF_CTRL: begin
                rdata_o[BIT_RUN]            = s_q.run;
                rdata_o[BIT_SEL +: SEL_W]   = s_q.sel;
                rdata_o[BIT_IE]             = s_q.ie;
                rdata_o[BIT_FLAG]           = s_q.flag;
            end
            OFF_COUNT: rdata_o = s_q.cnt;
            OFF_CMP:   rdata_o = s_q.cmp;
            default:   rdata_o = '0;
        endcase
    end

    assign irq_o = s_q.flag & s_q.ie;

    // R6
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !cnt_wr) |=> $stable(s_q.cnt));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && sel_tick && s_q.cnt == s_q.cmp && !cnt_wr)
        |=> (s_q.cnt == '0 && s_q.flag));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && sel_tick && s_q.cnt != s_q.cmp && !cnt_wr)
        |=> (s_q.cnt == $past(s_q.cnt) + 1'b1));

    // R5
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.flag) |-> $past(ctrl_wr && !wdata_i[BIT_FLAG]));

    // R7
    cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (s_q.cnt == $past(wdata_i)));
endmodule

// File: rtl/cmt_top.sv
module cmt_top #(
    parameter int NCH    = 2,
    parameter int CNT_W  = 16,
    parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int ADDR_W = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    irq
);
    localparam int NSEL  = 4;
    localparam int SEL_W = 2;

    logic [NSEL-1:0]  tick;
    logic [CH_W-1:0]  ch;
    logic [1:0]       off;
    logic [CNT_W-1:0] rd_vec [NCH];

    assign ch  = bus_addr[ADDR_W-1:2];
    assign off = bus_addr[1:0];

    cmt_prescale #(.NSEL(NSEL), .BASE_W(3), .STEP_W(2)) i_pre (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = (ch == CH_W'(g));
        cmt_channel #(.CNT_W(CNT_W), .SEL_W(SEL_W), .NSEL(NSEL)) i_ch (
            .clk(clk), .rst_n(rst_n), .tick_i(tick),
            .wr_i(bus_wr && hit), .rd_i(bus_rd && hit), .off_i(off),
            .wdata_i(bus_wdata), .rdata_o(rd_vec[g]), .irq_o(irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (ch == CH_W'(i)) bus_rdata = rd_vec[i];
    end

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));
endmodule

// File: tb/test_cmt_top.sv
module test_cmt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  irq;
    int          nvec = 0, nerr = 0;
    longint      cyc = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmt_top i_cmt_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    // {select code, compare value}
    localparam logic [17:0] VEC [0:5] = '{
        {2'd0, 16'd3}, {2'd1, 16'd2}, {2'd2, 16'd4},
        {2'd3, 16'd1}, {2'd0, 16'd0}, {2'd1, 16'd6}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bw(input logic ch, input logic [1:0] off, input logic [15:0] d);
        @(negedge clk); wr = 1'b1; addr = {ch, off}; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic br(input logic ch, input logic [1:0] off, output logic [15:0] d);
        @(negedge clk); rd = 1'b1; addr = {ch, off};
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic wait_irq0(output longint t);
        int n = 0;
        while (irq[0] !== 1'b1 && n < 6000) begin @(negedge clk); n++; end
        t = cyc;
        if (n >= 6000) chk("R3 timeout", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++; nvec++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, c1, c2;
        longint t1, t2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R8 unused offset
        chk("R1 irq", irq, 0);
        br(0, 2'd0, v); chk("R1 ctrl", v, 16'h0000);
        br(1, 2'd1, v); chk("R1 count", v, 16'h0000);
        br(0, 2'd2, v); chk("R1 compare", v, 16'hFFFF);
        br(1, 2'd3, v); chk("R8 offset3", v, 16'h0000);

        // R2 R3 period over all selects
        for (int i = 0; i < 6; i++) begin
            logic [1:0]  s;
            logic [15:0] cmpv, cfg;
            longint      per;
            s    = VEC[i][17:16];
            cmpv = VEC[i][15:0];
            cfg  = 16'h0009 | (16'(s) << 1);
            per  = (longint'(cmpv) + 1) * (longint'(8) << (2 * s));
            bw(0, 2'd0, 16'h0000);
            bw(0, 2'd2, cmpv);
            bw(0, 2'd1, 16'h0000);
            br(0, 2'd0, v);
            bw(0, 2'd0, cfg);
            wait_irq0(t1);
            br(0, 2'd0, v);
            chk("R3 flag set", v[4], 1);
            bw(0, 2'd0, cfg);
            chk("R5 cleared", irq[0], 0);
            chk("R8 other channel quiet", irq[1], 0);
            wait_irq0(t2);
            chk("R2/R3 period", 32'(t2 - t1), 32'(per));
            br(0, 2'd0, v);
            bw(0, 2'd0, 16'h0000);
        end

        // R4 gating by enable
        bw(1, 2'd2, 16'd2);
        bw(1, 2'd0, 16'h0001);
        repeat (40) @(negedge clk);
        chk("R4 disabled irq", irq[1], 0);
        br(1, 2'd0, v); chk("R4 flag w/o enable", v, 16'h0011);
        bw(1, 2'd0, 16'h0019);
        chk("R4 enabled irq", irq[1], 1);

        // R5 clear handshake
        bw(1, 2'd0, 16'h0008);
        chk("R5 unarmed clear ignored", irq[1], 1);
        br(1, 2'd0, v); chk("R5 flag kept", v, 16'h0018);
        bw(1, 2'd0, 16'h0008);
        chk("R5 armed clear", irq[1], 0);
        bw(1, 2'd0, 16'h0018);
        br(1, 2'd0, v); chk("R5 write one no effect", v, 16'h0008);

        // R7 count and compare writes
        bw(1, 2'd1, 16'd5);
        br(1, 2'd1, v); chk("R7 count write", v, 16'd5);
        bw(1, 2'd2, 16'h0100);
        br(1, 2'd2, v); chk("R7 compare write", v, 16'h0100);

        // R6 freeze and resume
        bw(1, 2'd0, 16'h0001);
        repeat (80) @(negedge clk);
        bw(1, 2'd0, 16'h0000);
        br(1, 2'd1, c1);
        chk("R6 run count", (c1 >= 15 && c1 <= 16), 1);
        repeat (50) @(negedge clk);
        br(1, 2'd1, v); chk("R6 frozen", v, c1);
        bw(1, 2'd0, 16'h0001);
        repeat (80) @(negedge clk);
        bw(1, 2'd0, 16'h0000);
        br(1, 2'd1, c2);
        chk("R6 resume", (c2 >= c1 + 10 && c2 <= c1 + 11), 1);

        // R7 write while running wins over increment
        bw(1, 2'd0, 16'h0007);
        bw(1, 2'd1, 16'h0040);
        br(1, 2'd1, v);
        chk("R7 write priority", (v == 16'h0040 || v == 16'h0041), 1);
        bw(1, 2'd0, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule